// File: doc/BRIEF.md
# Prefix-Pair Fusion Legality Checker

This block sits in a decode stage and looks at two decoded instructions that are adjacent in program order. The first is a predicated move-prefix instruction that copies a vector under a governing predicate. The second is the instruction after it. The block decides whether the two may be merged into one constructive operation. The fields of both instructions come in as already-decoded values. Two registered flags come out: one says the fused form may be used, the other says the pair breaks a pairing rule and must run as two separate operations.

The rules cover five things:
- the kind of operation the follower is;
- agreement on the destination vector register;
- agreement on the governing predicate register;
- agreement on the largest element size the follower touches, leaving out any fixed 64-bit wide-vector source;
- whether the destination is reused as another operand of the follower.

The decision is computed combinationally and registered once. It is visible in the cycle after the inputs are presented.

Top module: `prefix_fuse_checker`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `fuse_ok` and `pair_bad` are both 0.
- R2: When `pfx_valid` or `nxt_valid` is 0, both outputs are 0 one cycle later, whatever the other fields hold.
- R3: The follower class `nxt_class` is legal only for these codes: 1 (destructive binary), 2 (destructive ternary) and 3 (unary with merging predication). The codes 0, 4 (unary with zeroing predication), 6 and 7 make the pair illegal.
- R4: A follower of class 5, which is another move-prefix instruction, makes the pair illegal even when every other field matches.
- R5: The pair is illegal if `nxt_pg` differs from `pfx_pg`. Both fields are 3-bit predicate numbers 0 to 7.
- R6: The pair is illegal if `nxt_zd` differs from `pfx_zd`. Both fields are 5-bit vector register numbers.
- R7: The follower's maximum element size is the largest of two things: `nxt_dst_esz`, and the size of each source slot that is in use and not marked wide. Slot i uses bits [2i+1:2i] of `nxt_src_esz`, with codes 0=8, 1=16, 2=32 and 3=64 bits. The pair is illegal unless this maximum equals `pfx_esz`. The size of a slot marked wide in `nxt_src_wide` does not take part.
- R8: The pair is illegal if any in-use source slot i (bit i of `nxt_src_use`, register in bits [5i+4:5i] of `nxt_src_reg`) names `pfx_zd`. This holds for wide slots too. Slots that are not in use are ignored.
- R9: When both instructions are valid, exactly one output is 1: `fuse_ok` if R3 to R8 all pass, otherwise `pair_bad`.
- R10: The outputs change only at a rising clock edge. They reflect the inputs present at that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pfx_valid | input | 1 | Prefix instruction is valid |
| pfx_zd | input | 5 | Prefix destination vector register |
| pfx_pg | input | 3 | Prefix governing predicate register |
| pfx_esz | input | 2 | Prefix element size code |
| nxt_valid | input | 1 | Following instruction is valid |
| nxt_class | input | 3 | Following instruction class code |
| nxt_zd | input | 5 | Following destination vector register |
| nxt_pg | input | 3 | Following governing predicate register |
| nxt_dst_esz | input | 2 | Following destination element size code |
| nxt_src_use | input | 3 | Per source slot: slot is in use |
| nxt_src_reg | input | 15 | Per source slot: 5-bit register number |
| nxt_src_esz | input | 6 | Per source slot: 2-bit element size code |
| nxt_src_wide | input | 3 | Per source slot: fixed 64-bit wide operand |
| fuse_ok | output | 1 | Pair may be fused (registered) |
| pair_bad | output | 1 | Pair breaks a pairing rule (registered) |

## Verification
A wrong rule inside the block always shows up at the ports. One of the two flags flips for the exact pair that exposes the rule, in the cycle after that pair is presented. Because the outputs hold no state beyond that one register, a fault cannot hide and then surface later. Every rule therefore gets both a passing pair and a pair that fails only that rule, and the bench reads the result one edge later. Masking mistakes are probed with unused and wide slots that carry values which would otherwise alias or enlarge the size. A wrong output register would show as a missing or early flip relative to the driving edge.

// File: rtl/pfx_fuse_pkg.sv
package pfx_fuse_pkg;

  typedef enum logic [2:0] {
    OPC_OTHER  = 3'd0,
    OPC_DBIN   = 3'd1,
    OPC_DTER   = 3'd2,
    OPC_UMERGE = 3'd3,
    OPC_UZERO  = 3'd4,
    OPC_PREFIX = 3'd5,
    OPC_RSV6   = 3'd6,
    OPC_RSV7   = 3'd7
  } op_class_e;

  localparam int unsigned CLASS_W = 3;
  localparam int unsigned ESZ_W   = 2;

endpackage

// File: rtl/pfx_class_gate.sv
module pfx_class_gate
  import pfx_fuse_pkg::*;
(
  input  logic [CLASS_W-1:0] cls_i,
  output logic               cls_ok_o
);

  op_class_e cls;

  always_comb begin
    cls = op_class_e'(cls_i);
    unique case (cls)
      OPC_DBIN, OPC_DTER, OPC_UMERGE: cls_ok_o = 1'b1;
      default:                        cls_ok_o = 1'b0;
    endcase
  end

  // R4: a second move-prefix is never an acceptable follower
  always_comb begin
    if (cls_i == OPC_PREFIX) begin
      p_prefix_rejected_r4: assert (!cls_ok_o);
    end
  end

endmodule

// File: rtl/pfx_size_max.sv
module pfx_size_max
  import pfx_fuse_pkg::*;
#(
  parameter int unsigned SRC_N = 3
) (
  input  logic [ESZ_W-1:0]       dst_esz_i,
  input  logic [SRC_N-1:0]       use_i,
  input  logic [SRC_N-1:0]       wide_i,
  input  logic [SRC_N*ESZ_W-1:0] esz_i,
  output logic [ESZ_W-1:0]       max_esz_o
);

  logic [SRC_N-1:0][ESZ_W-1:0] slot_eff;

  // Wide or unused slots contribute the smallest size code
  for (genvar gi = 0; gi < SRC_N; gi++) begin : g_slot
    logic counts;
    assign counts       = use_i[gi] & ~wide_i[gi];
    assign slot_eff[gi] = counts ? esz_i[gi*ESZ_W +: ESZ_W] : '0;
  end

  always_comb begin
    max_esz_o = dst_esz_i;
    for (int i = 0; i < SRC_N; i++) begin
      if (slot_eff[i] > max_esz_o) max_esz_o = slot_eff[i];
    end
  end

  // R7: result never below the destination size, and a wide slot never raises it
  always_comb begin
    p_max_not_below_dst_r7: assert (max_esz_o >= dst_esz_i);
    for (int i = 0; i < SRC_N; i++) begin
      if (use_i[i] && !wide_i[i]) begin
        p_max_covers_slot_r7: assert (max_esz_o >= esz_i[i*ESZ_W +: ESZ_W]);
      end
    end
  end

endmodule

// File: rtl/pfx_alias_scan.sv
module pfx_alias_scan #(
  parameter int unsigned SRC_N = 3,
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0]       dst_i,
  input  logic [SRC_N-1:0]       use_i,
  input  logic [SRC_N*REG_W-1:0] regs_i,
  output logic                   hit_o
);

  logic [SRC_N-1:0] slot_hit;

  for (genvar gi = 0; gi < SRC_N; gi++) begin : g_cmp
    assign slot_hit[gi] = use_i[gi] & (regs_i[gi*REG_W +: REG_W] == dst_i);
  end

  assign hit_o = |slot_hit;

  // R8: an unused slot never produces a hit
  always_comb begin
    if (use_i == '0) begin
      p_unused_no_alias_r8: assert (!hit_o);
    end
  end

endmodule

// File: rtl/prefix_fuse_checker.sv
module prefix_fuse_checker
  import pfx_fuse_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned PRED_W = 3,
  parameter int unsigned SRC_N  = 3,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pfx_valid,
  input  logic [REG_W-1:0]         pfx_zd,
  input  logic [PRED_W-1:0]        pfx_pg,
  input  logic [ESZ_W-1:0]         pfx_esz,
  input  logic                     nxt_valid,
  input  logic [CLASS_W-1:0]       nxt_class,
  input  logic [REG_W-1:0]         nxt_zd,
  input  logic [PRED_W-1:0]        nxt_pg,
  input  logic [ESZ_W-1:0]         nxt_dst_esz,
  input  logic [SRC_N-1:0]         nxt_src_use,
  input  logic [SRC_N*REG_W-1:0]   nxt_src_reg,
  input  logic [SRC_N*ESZ_W-1:0]   nxt_src_esz,
  input  logic [SRC_N-1:0]         nxt_src_wide,
  output logic                     fuse_ok,
  output logic                     pair_bad
);

  // Reset: asserted asynchronously, released through a short flop chain
  logic [SYNC_N-1:0] rst_chain_q;
  logic              rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= '0;
    else        rst_chain_q <= {rst_chain_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_ok_n = rst_chain_q[SYNC_N-1];

  // Rule evaluation
  logic             cls_ok;
  logic [ESZ_W-1:0] nxt_max_esz;
  logic             alias_hit;
  logic             pg_match, zd_match, esz_match;
  logic             rules_ok, pair_live;

  pfx_class_gate u_class (
    .cls_i    (nxt_class),
    .cls_ok_o (cls_ok)
  );

  pfx_size_max #(.SRC_N(SRC_N)) u_size (
    .dst_esz_i (nxt_dst_esz),
    .use_i     (nxt_src_use),
    .wide_i    (nxt_src_wide),
    .esz_i     (nxt_src_esz),
    .max_esz_o (nxt_max_esz)
  );

  pfx_alias_scan #(.SRC_N(SRC_N), .REG_W(REG_W)) u_alias (
    .dst_i  (pfx_zd),
    .use_i  (nxt_src_use),
    .regs_i (nxt_src_reg),
    .hit_o  (alias_hit)
  );

  always_comb begin
    pg_match  = (nxt_pg == pfx_pg);
    zd_match  = (nxt_zd == pfx_zd);
    esz_match = (nxt_max_esz == pfx_esz);
    rules_ok  = cls_ok & pg_match & zd_match & esz_match & ~alias_hit;
    pair_live = pfx_valid & nxt_valid;
  end

  // Next state and register
  logic fuse_d, bad_d, out_en;
  logic fuse_q, bad_q;

  always_comb begin
    out_en = 1'b1;
    fuse_d = pair_live &  rules_ok;
    bad_d  = pair_live & ~rules_ok;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      fuse_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (out_en) begin
      fuse_q <= fuse_d;
      bad_q  <= bad_d;
    end
  end

  assign fuse_ok  = fuse_q;
  assign pair_bad = bad_q;

  // Assertions
  p_never_both_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(fuse_ok && pair_bad));

  p_invalid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!pfx_valid || !nxt_valid) |=> (!fuse_ok && !pair_bad));

  p_live_decided_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (pfx_valid && nxt_valid) |=> $countones({fuse_ok, pair_bad}) == 1);

  p_pred_mismatch_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (pfx_valid && nxt_valid && (pfx_pg != nxt_pg)) |=> pair_bad);

  p_dest_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (pfx_valid && nxt_valid && (pfx_zd != nxt_zd)) |=> pair_bad);

  p_prefix_follow_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (pfx_valid && nxt_valid && (nxt_class == OPC_PREFIX)) |=> !fuse_ok);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_ok_n |-> (!fuse_ok && !pair_bad));

endmodule

// File: tb/prefix_fuse_checker_bench.sv
module prefix_fuse_checker_bench;

  localparam time CLK_P = 10ns;
  localparam int  WATCHDOG_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pfx_valid;
  logic [4:0]  pfx_zd;
  logic [2:0]  pfx_pg;
  logic [1:0]  pfx_esz;
  logic        nxt_valid;
  logic [2:0]  nxt_class;
  logic [4:0]  nxt_zd;
  logic [2:0]  nxt_pg;
  logic [1:0]  nxt_dst_esz;
  logic [2:0]  nxt_src_use;
  logic [14:0] nxt_src_reg;
  logic [5:0]  nxt_src_esz;
  logic [2:0]  nxt_src_wide;
  logic        fuse_ok;
  logic        pair_bad;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_P/2) clk = ~clk;

  prefix_fuse_checker u_prefix_fuse_checker (
    .clk, .rst_n, .pfx_valid, .pfx_zd, .pfx_pg, .pfx_esz,
    .nxt_valid, .nxt_class, .nxt_zd, .nxt_pg, .nxt_dst_esz,
    .nxt_src_use, .nxt_src_reg, .nxt_src_esz, .nxt_src_wide,
    .fuse_ok, .pair_bad
  );

  task automatic check(input string req, input logic exp_f, input logic exp_b);
    vectors++;
    if (fuse_ok !== exp_f || pair_bad !== exp_b) begin
      miscompares++;
      $display("FAIL %s: fuse_ok/pair_bad = %b/%b, expected %b/%b",
               req, fuse_ok, pair_bad, exp_f, exp_b);
    end
  endtask

  // A legal baseline pair: z5, p2, 32-bit, source z9
  task automatic set_good();
    pfx_valid = 1; pfx_zd = 5; pfx_pg = 2; pfx_esz = 2;
    nxt_valid = 1; nxt_class = 1; nxt_zd = 5; nxt_pg = 2; nxt_dst_esz = 2;
    nxt_src_use = 3'b001; nxt_src_reg = {5'd0, 5'd0, 5'd9};
    nxt_src_esz = {2'd0, 2'd0, 2'd2}; nxt_src_wide = 3'b000;
  endtask

  // Drive at a falling edge, sample one rising edge later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; set_good();
    repeat (3) @(negedge clk);
    check("R1 during reset", 0, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 just after release", 0, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_invalid();
    set_good(); pfx_valid = 0; step(); check("R2 prefix invalid", 0, 0);
    set_good(); nxt_valid = 0; nxt_class = 5; step(); check("R2 follower invalid", 0, 0);
    set_good(); pfx_valid = 0; nxt_valid = 0; nxt_pg = 7; step(); check("R2 both invalid", 0, 0);
  endtask

  task automatic t_classes();
    set_good(); nxt_class = 1; step(); check("R3 destructive binary", 1, 0);
    set_good(); nxt_class = 2; nxt_src_use = 3'b011;
    nxt_src_reg = {5'd0, 5'd12, 5'd9}; nxt_src_esz = {2'd0, 2'd1, 2'd2};
    step(); check("R3 destructive ternary", 1, 0);
    set_good(); nxt_class = 3; step(); check("R3 unary merging", 1, 0);
    set_good(); nxt_class = 4; step(); check("R3 unary zeroing", 0, 1);
    set_good(); nxt_class = 0; step(); check("R3 other class", 0, 1);
    set_good(); nxt_class = 7; step(); check("R3 reserved class", 0, 1);
  endtask

  task automatic t_prefix_follow();
    set_good(); nxt_class = 5; step(); check("R4 prefix after prefix", 0, 1);
  endtask

  task automatic t_pred();
    set_good(); pfx_pg = 7; nxt_pg = 7; step(); check("R5 matching p7", 1, 0);
    set_good(); nxt_pg = 3; step(); check("R5 predicate mismatch", 0, 1);
  endtask

  task automatic t_dest();
    set_good(); pfx_zd = 31; nxt_zd = 31; step(); check("R6 matching z31", 1, 0);
    set_good(); nxt_zd = 6; step(); check("R6 destination mismatch", 0, 1);
  endtask

  task automatic t_size();
    set_good(); pfx_esz = 0; nxt_dst_esz = 0; nxt_src_esz = 6'd0;
    step(); check("R7 byte sizes", 1, 0);
    set_good(); nxt_dst_esz = 1; step(); check("R7 source raises max to prefix size", 1, 0);
    set_good(); nxt_src_esz = {2'd0, 2'd0, 2'd3}; step(); check("R7 source larger", 0, 1);
    set_good(); nxt_dst_esz = 3; nxt_src_esz = 6'd0; pfx_esz = 2; step(); check("R7 dest larger", 0, 1);
    set_good(); nxt_src_use = 3'b011; nxt_src_reg = {5'd0, 5'd14, 5'd9};
    nxt_src_esz = {2'd0, 2'd3, 2'd2}; nxt_src_wide = 3'b010;
    step(); check("R7 wide 64-bit slot ignored", 1, 0);
    nxt_src_wide = 3'b000; step(); check("R7 same slot not wide", 0, 1);
    set_good(); nxt_src_esz = {2'd3, 2'd3, 2'd2}; step(); check("R7 unused slot sizes ignored", 1, 0);
  endtask

  task automatic t_alias();
    set_good(); nxt_src_reg = {5'd0, 5'd0, 5'd5}; step(); check("R8 alias slot0", 0, 1);
    set_good(); nxt_src_use = 3'b111; nxt_src_reg = {5'd5, 5'd8, 5'd9};
    nxt_src_esz = {2'd2, 2'd2, 2'd2}; step(); check("R8 alias slot2", 0, 1);
    set_good(); nxt_src_use = 3'b011; nxt_src_reg = {5'd0, 5'd5, 5'd9};
    nxt_src_esz = {2'd0, 2'd3, 2'd2}; nxt_src_wide = 3'b010;
    step(); check("R8 alias via wide slot", 0, 1);
    set_good(); nxt_src_reg = {5'd5, 5'd5, 5'd9}; step(); check("R8 unused slots naming dest ignored", 1, 0);
  endtask

  task automatic t_latency();
    set_good(); step(); check("R10 legal settled", 1, 0);
    nxt_pg = 0;
    #1; check("R10 no change before edge", 1, 0);
    step(); check("R10 updated after edge", 0, 1);
    set_good();
    #1; check("R10 holds illegal until edge", 0, 1);
    step(); check("R9 legal again", 1, 0);
  endtask

  initial begin
    #(CLK_P * WATCHDOG_CYC);
    miscompares++;
    $display("FAIL R10 watchdog expired, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_invalid();
    t_classes();
    t_prefix_follow();
    t_pred();
    t_dest();
    t_size();
    t_alias();
    t_latency();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule